// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between the six active-high PWM commands of a three-phase bridge (one high-side and one low-side command per phase) and the six gate-enable outputs. It removes input pulses that are too short and keeps a programmable gap between the two gates of a phase. It also forces both gates of a phase off whenever both of that phase's commands are high. It takes a filtered short-circuit flag, a trip flag and a recovered flag for the low-side supply, and the same pair of flags for each high-side supply.

A short-circuit or a low-side supply trip blocks all low-side gates and pulls the registered active-low fault output down. After a short-circuit the fault output stays low for exactly the programmed number of cycles. After a low-side supply trip it stays low for at least that many cycles, and for as long as the supply has not reported recovery. A high-side supply trip blocks only the high-side gate of its own phase and does not touch the fault output. After any block, a gate stays off until its own command shows a fresh low-to-high edge. Each gate re-arms on its own.

Each gate channel runs a two-state machine. LOCKED goes to ARMED on `arm_edge`, which is a filtered rising edge while no block is present. ARMED goes back to LOCKED on `blocked`, which is any protection block. The fault sequencer has three states: IDLE, SHORT (fixed-width pulse) and UVHOLD (supply hold). Its transitions are `sc_enter` (IDLE to SHORT), `uv_enter` (IDLE or SHORT to UVHOLD), `sc_retrigger` (SHORT or UVHOLD reloads the counter), `pulse_done` (SHORT to IDLE when the counter is spent), and `uv_release` (UVHOLD to IDLE once the counter is spent and the supply has recovered).

Top module: `gate_guard`

## Requirements
- R1: During reset and after reset, all gates are off and `fault_n` is 1. A command that is held high through reset does not turn its gate on until the command has gone low and then high again.
- R2: A command level is accepted only after it has stayed unchanged for `cfg_min_pw` cycles (at least 1). With `cfg_min_pw`=2, a gate turns on 3 cycles after its command rises, and a 1-cycle command pulse is ignored.
- R3: A gate turns on only after the other gate of its phase has been off for at least `cfg_dead` cycles. With `cfg_dead`=3, a high-side gate whose command rises while the low-side command falls comes on 7 cycles after the change.
- R4: Whenever both accepted commands of a phase are high, both gates of that phase are off. The gate comes back when the other command drops, without a new edge.
- R5: A cycle with `sc_det`=1 turns all low-side gates off at the next clock edge and leaves the high-side gates unchanged.
- R6: After `sc_det` the fault output is low for exactly `cfg_fault_len` cycles, starting at the next edge. A new `sc_det` during the pulse restarts the full width.
- R7: After any block ends, each gate stays off while its command remains high. It turns on again only after a new low-to-high edge of its own command.
- R8: A `lo_uv_trip` blocks all low-side gates and drives `fault_n` low for at least `cfg_fault_len` cycles. `fault_n` stays low while neither `lo_uv_trip` nor `lo_uv_ok` is asserted (hysteresis band). It returns to 1 one edge after `lo_uv_ok` once the minimum width has passed.
- R9: `hi_uv_trip[i]` turns off only `gate_hi[i]` at the next edge. It holds that gate off until `hi_uv_ok[i]` and a new command edge arrive, and never changes `fault_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi | input | NPH | High-side commands, bit i is phase i |
| pwm_lo | input | NPH | Low-side commands, bit i is phase i |
| sc_det | input | 1 | Filtered short-circuit detect |
| lo_uv_trip | input | 1 | Low-side supply below trip level |
| lo_uv_ok | input | 1 | Low-side supply above reset level |
| hi_uv_trip | input | NPH | High-side supply of phase i below trip level |
| hi_uv_ok | input | NPH | High-side supply of phase i above reset level |
| cfg_fault_len | input | LEN_W | Fault pulse width in cycles |
| cfg_min_pw | input | PW_W | Minimum accepted command width in cycles |
| cfg_dead | input | DT_W | Minimum off gap of the opposite gate in cycles |
| gate_hi | output | NPH | High-side gate enables |
| gate_lo | output | NPH | Low-side gate enables |
| fault_n | output | 1 | Registered active-low fault indication |

## Verification
The hardest case to reach from the ports is the interaction between dead time, filtering and arming. A high-side gate is armed while its partner is still on, so the arm edge is recorded but the gate must wait out the gap. The stimulus gets there by dropping one command and raising the other in the same cycle. A second hard case is a short-circuit that arrives while a pulse is already counting; the stimulus fires two short detects three cycles apart and checks that the pulse ends on the later one. A third is a supply trip that sits in the hysteresis band for longer than the pulse width, and the bench checks that the fault output is released only by the recovered flag.

// File: rtl/gg_pkg.sv
package gg_pkg;
    typedef enum logic [1:0] {
        FLT_IDLE    = 2'd0,
        FLT_SHORT   = 2'd1,
        FLT_UVHOLD  = 2'd2
    } flt_state_t;

    typedef enum logic {
        CH_LOCKED = 1'b0,
        CH_ARMED  = 1'b1
    } ch_state_t;
endpackage

// File: rtl/gg_channel.sv
module gg_channel
    import gg_pkg::*;
#(
    parameter int PW_W = 8,
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [PW_W-1:0] cfg_min_pw,
    input  logic [DT_W-1:0] cfg_dead,
    input  logic            block,
    input  logic            mate_lvl_nxt,
    input  logic            mate_gate,
    output logic            lvl_nxt,
    output logic            gate
);
    localparam logic [DT_W-1:0] OFF_MAX = {DT_W{1'b1}};

    logic            in_q;
    logic            lvl;
    logic [PW_W-1:0] pw_cnt;
    logic [PW_W-1:0] pw_cnt_nxt;
    logic [PW_W-1:0] pw_lim;
    logic [DT_W-1:0] off_cnt;
    ch_state_t       st;
    ch_state_t       st_nxt;
    logic            arm_edge;
    logic            permit;

    // width filter: a new level is accepted after it held for cfg_min_pw cycles
    assign pw_lim = (cfg_min_pw == '0) ? '0 : cfg_min_pw - 1'b1;

    always_comb begin
        lvl_nxt    = lvl;
        pw_cnt_nxt = '0;
        if (in_q != lvl) begin
            if (pw_cnt >= pw_lim) begin
                lvl_nxt = in_q;
            end else begin
                pw_cnt_nxt = pw_cnt + 1'b1;
            end
        end
    end

    assign arm_edge = lvl_nxt && !lvl;

    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_LOCKED: if (!block && arm_edge) st_nxt = CH_ARMED;
            CH_ARMED:  if (block) st_nxt = CH_LOCKED;
            default:   st_nxt = CH_LOCKED;
        endcase
    end

    assign permit = !mate_gate && (off_cnt >= cfg_dead) && !(lvl_nxt && mate_lvl_nxt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CH_LOCKED;
            in_q   <= 1'b1;
            lvl    <= 1'b1;
            pw_cnt <= '0;
        end else begin
            st     <= st_nxt;
            in_q   <= raw;
            lvl    <= lvl_nxt;
            pw_cnt <= pw_cnt_nxt;
        end
    end

    // outputs and gap counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate    <= 1'b0;
            off_cnt <= '0;
        end else begin
            gate <= (st_nxt == CH_ARMED) && lvl_nxt && permit;
            if (mate_gate) begin
                off_cnt <= '0;
            end else if (off_cnt != OFF_MAX) begin
                off_cnt <= off_cnt + 1'b1;
            end
        end
    end

    // R7
    blk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !gate);

    // R3
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> !$past(mate_gate));
endmodule

// File: rtl/gg_phase.sv
module gg_phase #(
    parameter int PW_W = 8,
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_hi,
    input  logic            cmd_lo,
    input  logic            lo_block,
    input  logic            hs_trip,
    input  logic            hs_ok,
    input  logic [PW_W-1:0] cfg_min_pw,
    input  logic [DT_W-1:0] cfg_dead,
    output logic            gate_hi,
    output logic            gate_lo
);
    logic hs_low;
    logic hs_low_nxt;
    logic hi_lvl_nxt;
    logic lo_lvl_nxt;

    // high-side supply latch with separate trip and recover flags
    assign hs_low_nxt = hs_trip ? 1'b1 : (hs_ok ? 1'b0 : hs_low);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_low <= 1'b0;
        end else begin
            hs_low <= hs_low_nxt;
        end
    end

    gg_channel #(.PW_W(PW_W), .DT_W(DT_W)) u_hi (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw          (cmd_hi),
        .cfg_min_pw   (cfg_min_pw),
        .cfg_dead     (cfg_dead),
        .block        (hs_low_nxt),
        .mate_lvl_nxt (lo_lvl_nxt),
        .mate_gate    (gate_lo),
        .lvl_nxt      (hi_lvl_nxt),
        .gate         (gate_hi)
    );

    gg_channel #(.PW_W(PW_W), .DT_W(DT_W)) u_lo (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw          (cmd_lo),
        .cfg_min_pw   (cfg_min_pw),
        .cfg_dead     (cfg_dead),
        .block        (lo_block),
        .mate_lvl_nxt (hi_lvl_nxt),
        .mate_gate    (gate_hi),
        .lvl_nxt      (lo_lvl_nxt),
        .gate         (gate_lo)
    );

    // R4
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
endmodule

// File: rtl/gg_fault_seq.sv
module gg_fault_seq
    import gg_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_det,
    input  logic             uv_trip,
    input  logic             uv_ok,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             lo_block,
    output logic             fault_n
);
    flt_state_t       st;
    flt_state_t       st_nxt;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_nxt;
    logic [LEN_W-1:0] len_m1;
    logic             uv_low;
    logic             uv_low_nxt;

    assign len_m1     = (cfg_len == '0) ? '0 : cfg_len - 1'b1;
    assign uv_low_nxt = uv_trip ? 1'b1 : (uv_ok ? 1'b0 : uv_low);

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            FLT_IDLE: begin
                if (uv_trip) begin
                    st_nxt  = FLT_UVHOLD;
                    cnt_nxt = len_m1;
                end else if (sc_det) begin
                    st_nxt  = FLT_SHORT;
                    cnt_nxt = len_m1;
                end
            end
            FLT_SHORT: begin
                if (uv_trip) begin
                    st_nxt  = FLT_UVHOLD;
                    cnt_nxt = len_m1;
                end else if (sc_det) begin
                    cnt_nxt = len_m1;
                end else if (cnt == '0) begin
                    st_nxt = FLT_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            FLT_UVHOLD: begin
                if (sc_det || uv_trip) begin
                    cnt_nxt = len_m1;
                end else if (cnt != '0) begin
                    cnt_nxt = cnt - 1'b1;
                end else if (!uv_low_nxt) begin
                    st_nxt = FLT_IDLE;
                end
            end
            default: st_nxt = FLT_IDLE;
        endcase
    end

    assign lo_block = (st_nxt != FLT_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FLT_IDLE;
            cnt    <= '0;
            uv_low <= 1'b0;
        end else begin
            st     <= st_nxt;
            cnt    <= cnt_nxt;
            uv_low <= uv_low_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_n <= 1'b1;
        end else begin
            fault_n <= (st_nxt == FLT_IDLE);
        end
    end

    // R6
    sc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_det |=> !fault_n);

    // R8
    uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low |-> !fault_n);
endmodule

// File: rtl/gate_guard.sv
module gate_guard #(
    parameter int NPH   = 3,
    parameter int PW_W  = 8,
    parameter int DT_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPH-1:0]   pwm_hi,
    input  logic [NPH-1:0]   pwm_lo,
    input  logic             sc_det,
    input  logic             lo_uv_trip,
    input  logic             lo_uv_ok,
    input  logic [NPH-1:0]   hi_uv_trip,
    input  logic [NPH-1:0]   hi_uv_ok,
    input  logic [LEN_W-1:0] cfg_fault_len,
    input  logic [PW_W-1:0]  cfg_min_pw,
    input  logic [DT_W-1:0]  cfg_dead,
    output logic [NPH-1:0]   gate_hi,
    output logic [NPH-1:0]   gate_lo,
    output logic             fault_n
);
    logic lo_block;

    gg_fault_seq #(.LEN_W(LEN_W)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_det   (sc_det),
        .uv_trip  (lo_uv_trip),
        .uv_ok    (lo_uv_ok),
        .cfg_len  (cfg_fault_len),
        .lo_block (lo_block),
        .fault_n  (fault_n)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        gg_phase #(.PW_W(PW_W), .DT_W(DT_W)) u_ph (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_hi     (pwm_hi[p]),
            .cmd_lo     (pwm_lo[p]),
            .lo_block   (lo_block),
            .hs_trip    (hi_uv_trip[p]),
            .hs_ok      (hi_uv_ok[p]),
            .cfg_min_pw (cfg_min_pw),
            .cfg_dead   (cfg_dead),
            .gate_hi    (gate_hi[p]),
            .gate_lo    (gate_lo[p])
        );

        // R9
        hs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hi_uv_trip[p] |=> !gate_hi[p]);
    end

    // R5
    sc_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_det |=> (gate_lo == '0));

    // R5
    sc_hs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_det && !lo_uv_trip && (hi_uv_trip == '0) && $stable(pwm_hi)
         && (pwm_hi == '0) && (gate_hi == '0)) |=> (gate_hi == '0));

    // R9
    hs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && !sc_det && !lo_uv_trip) |=> fault_n);
endmodule

// File: tb/sim_gate_guard.sv
module sim_gate_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  pwm_hi, pwm_lo, hi_uv_trip, hi_uv_ok;
    logic        sc_det, lo_uv_trip, lo_uv_ok;
    logic [15:0] cfg_fault_len;
    logic [7:0]  cfg_min_pw, cfg_dead;
    logic [2:0]  gate_hi, gate_lo;
    logic        fault_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int         due;
        logic [2:0] gh;
        logic [2:0] gl;
        logic       fn;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    gate_guard u0 (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .sc_det(sc_det), .lo_uv_trip(lo_uv_trip), .lo_uv_ok(lo_uv_ok),
        .hi_uv_trip(hi_uv_trip), .hi_uv_ok(hi_uv_ok),
        .cfg_fault_len(cfg_fault_len), .cfg_min_pw(cfg_min_pw), .cfg_dead(cfg_dead),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    task automatic push(input int dly, input logic [2:0] gh, input logic [2:0] gl,
                        input logic fn, input string tag);
        exp_t it;
        int   idx;
        it.due = cyc + dly;
        it.gh  = gh;
        it.gl  = gl;
        it.fn  = fn;
        it.tag = tag;
        idx = sb.size();
        for (int k = 0; k < sb.size(); k++) begin
            if (sb[k].due > it.due) begin
                idx = k;
                break;
            end
        end
        sb.insert(idx, it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // monitor: pops expected items when their cycle comes up
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            total++;
            if (it.due != cyc || gate_hi !== it.gh || gate_lo !== it.gl || fault_n !== it.fn) begin
                bad++;
                $display("FAIL %s cyc=%0d: got hi=%b lo=%b fn=%b expected hi=%b lo=%b fn=%b",
                         it.tag, cyc, gate_hi, gate_lo, fault_n, it.gh, it.gl, it.fn);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got running expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwm_hi = 3'b001; pwm_lo = 3'b000;
        sc_det = 1'b0; lo_uv_trip = 1'b0; lo_uv_ok = 1'b0;
        hi_uv_trip = 3'b000; hi_uv_ok = 3'b000;
        cfg_fault_len = 16'd5; cfg_min_pw = 8'd2; cfg_dead = 8'd3;
        step(3);
        push(1, 3'b000, 3'b000, 1'b1, "R1 in reset");
        step(2);
        rst_n = 1'b1;
        push(6, 3'b000, 3'b000, 1'b1, "R1 held input");
        step(7);

        // R2 / R1: fresh edge after low, 3-cycle latency
        pwm_hi = 3'b000; step(4);
        pwm_hi = 3'b001;
        push(2, 3'b000, 3'b000, 1'b1, "R2 not yet");
        push(3, 3'b001, 3'b000, 1'b1, "R2 on");
        step(4);

        // R2: one-cycle pulse ignored
        pwm_lo = 3'b010; step(1); pwm_lo = 3'b000;
        push(3, 3'b001, 3'b000, 1'b1, "R2 short pulse");
        step(4);

        pwm_lo = 3'b010;
        push(3, 3'b001, 3'b010, 1'b1, "R2 lo on");
        step(4);

        // R3: swap in one cycle
        pwm_lo = 3'b000; pwm_hi = 3'b011;
        push(3, 3'b001, 3'b000, 1'b1, "R3 lo off");
        push(6, 3'b001, 3'b000, 1'b1, "R3 gap");
        push(7, 3'b011, 3'b000, 1'b1, "R3 hi on");
        step(8);

        // R4: both commands of phase 0
        pwm_lo = 3'b001;
        push(3, 3'b010, 3'b000, 1'b1, "R4 both off");
        step(4);
        pwm_lo = 3'b000;
        push(3, 3'b011, 3'b000, 1'b1, "R4 back");
        step(4);

        pwm_lo = 3'b100;
        push(3, 3'b011, 3'b100, 1'b1, "R5 setup");
        step(4);

        // R5 / R6 / R7: short-circuit pulse
        sc_det = 1'b1;
        push(1, 3'b011, 3'b000, 1'b0, "R5 lo off hi kept");
        push(5, 3'b011, 3'b000, 1'b0, "R6 last low");
        push(6, 3'b011, 3'b000, 1'b1, "R6 released");
        push(8, 3'b011, 3'b000, 1'b1, "R7 held input stays off");
        step(1); sc_det = 1'b0;
        step(8);
        pwm_lo = 3'b000; step(4);
        pwm_lo = 3'b100;
        push(3, 3'b011, 3'b100, 1'b1, "R7 rearm");
        step(4);

        // R6: retrigger
        sc_det = 1'b1;
        push(1, 3'b011, 3'b000, 1'b0, "R6 first");
        push(8, 3'b011, 3'b000, 1'b0, "R6 restart low");
        push(9, 3'b011, 3'b000, 1'b1, "R6 restart end");
        step(1); sc_det = 1'b0;
        step(2); sc_det = 1'b1;
        step(1); sc_det = 1'b0;
        step(7);

        // R8: hold in hysteresis band
        lo_uv_trip = 1'b1;
        push(1, 3'b011, 3'b000, 1'b0, "R8 trip");
        push(12, 3'b011, 3'b000, 1'b0, "R8 band hold");
        step(1); lo_uv_trip = 1'b0;
        step(11);
        lo_uv_ok = 1'b1;
        push(1, 3'b011, 3'b000, 1'b1, "R8 recover");
        step(2);
        lo_uv_ok = 1'b0;
        step(1);

        // R8: minimum width when recovery is early
        lo_uv_trip = 1'b1;
        push(5, 3'b011, 3'b000, 1'b0, "R8 min width");
        push(6, 3'b011, 3'b000, 1'b1, "R8 min end");
        step(1); lo_uv_trip = 1'b0; lo_uv_ok = 1'b1;
        step(7);
        lo_uv_ok = 1'b0;

        // R9: high-side supply of phase 0
        hi_uv_trip = 3'b001;
        push(1, 3'b010, 3'b000, 1'b1, "R9 own gate off");
        step(1); hi_uv_trip = 3'b000; hi_uv_ok = 3'b001;
        push(4, 3'b010, 3'b000, 1'b1, "R9 stays off");
        step(1); hi_uv_ok = 3'b000;
        step(4);
        pwm_hi = 3'b010; step(4);
        pwm_hi = 3'b011;
        push(3, 3'b011, 3'b000, 1'b1, "R9 rearm");
        step(5);

        if (sb.size() != 0) begin
            bad++;
            total++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule